// File: doc/BRIEF.md
# DSD-over-PCM Frame Detector

This block watches a stream of stereo frames, each carrying a 32-bit left word and a 32-bit right word, and decides whether the stream holds packed one-bit audio rather than ordinary PCM. It checks the top byte of each word against a marker that alternates from frame to frame. A long unbroken run of correct markers moves the block into DSD mode. Once in DSD mode, the block tolerates a frame whose marker is out of phase in a specific way. Any other break returns it to PCM mode.

Frames arrive on a valid/ready stream. The block never applies back-pressure: `in_ready` is held high, and a frame is accepted in every cycle where `in_valid` is high. A downstream mixer or output stage reads `dsd_mode` to pick its data path. It can use `mode_toggle` to start a reconfiguration on each change.

Top module: `dop_frame_detector`

## Requirements
- R1: The marker of a channel word is its bits [31:24]. Bits [23:0] have no effect on any output or on the internal state.
- R2: After reset, `dsd_mode` is 0, `mode_toggle` is 0, the run count is 0 and the expected marker is 0x05.
- R3: A frame matches only if the left and right marker bytes both equal the expected marker. On a match, the expected marker is XORed with 0xFF, so it alternates between 0x05 and 0xFA, and the run count increments, saturating at its maximum.
- R4: In PCM mode, the accepted frame that brings the run count to 32 sets `dsd_mode` to 1 at that clock edge and clears the run count.
- R5: At that entry edge the expected marker is XORed with 0xFF a second time, so it keeps the value of the marker that was just matched.
- R6: An accepted frame that does not match clears the run count.
- R7: In DSD mode, a non-matching frame whose left marker equals the expected marker XOR 0xFF keeps `dsd_mode` at 1.
- R8: In DSD mode, any other non-matching frame clears `dsd_mode` at that edge.
- R9: `mode_toggle` is high for exactly the one cycle after each edge where `dsd_mode` changes, and is low at all other times.
- R10: While `in_valid` is 0, no state changes. `in_ready` is always 1.
- R11: A non-matching frame leaves the expected marker unchanged. Only reset returns it to 0x05.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Frame present on the stream |
| in_ready | output | 1 | Always 1; the block never stalls the stream |
| in_left | input | 32 | Left channel word |
| in_right | input | 32 | Right channel word |
| dsd_mode | output | 1 | 1 while the stream is taken as DSD over PCM |
| mode_toggle | output | 1 | One-cycle pulse after each mode change |

## Verification
The hardest state to reach from the ports is the tolerant-exit path. It needs DSD mode, and then a frame whose left marker is the complement of the expected marker. Because of the double inversion at entry, this happens naturally on the first frame after entry when the source keeps alternating. The bench drives a continuously alternating stream with random lower bits through entry, so this tolerant frame occurs without special timing. It then injects single-channel breaks and idle cycles in both modes. A behavioural model tracks the expected marker, the run and the mode, and is compared against the outputs every cycle.

// File: rtl/dop_pkg.sv
package dop_pkg;
  typedef enum logic {
    MODE_PCM = 1'b0,
    MODE_DSD = 1'b1
  } stream_mode_e;

  localparam int unsigned SAMPLE_W = 32;
  localparam int unsigned TAG_W    = 8;
endpackage

// File: rtl/dop_marker_compare.sv
module dop_marker_compare #(
  parameter int unsigned TAG_W = 8
) (
  input  logic [TAG_W-1:0] left_tag,
  input  logic [TAG_W-1:0] right_tag,
  input  logic [TAG_W-1:0] expect_tag,
  output logic             frame_match,
  output logic             left_is_inverse
);
  logic [TAG_W-1:0] inverse_tag;

  always_comb begin
    inverse_tag     = ~expect_tag;
    frame_match     = (left_tag == expect_tag) && (right_tag == expect_tag);
    left_is_inverse = (left_tag == inverse_tag);
  end
endmodule

// File: rtl/dop_marker_tracker.sv
module dop_marker_tracker #(
  parameter int unsigned      TAG_W = 8,
  parameter logic [TAG_W-1:0] SEED  = 8'h05
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             frame_match,
  input  logic             enter_dsd,
  output logic [TAG_W-1:0] expect_tag
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      expect_tag <= SEED;
    end else if (accept && frame_match) begin
      // the second inversion at entry cancels the first
      if (!enter_dsd) expect_tag <= ~expect_tag;
    end
  end

  assert_hold_on_miss_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !frame_match) |=> $stable(expect_tag));
  assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(expect_tag));
  assert_keep_on_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && enter_dsd) |=> $stable(expect_tag));
endmodule

// File: rtl/dop_run_counter.sv
module dop_run_counter #(
  parameter int unsigned TARGET = 32,
  localparam int unsigned CNT_W = $clog2(TARGET + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic frame_match,
  input  logic enter_dsd,
  output logic run_complete
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W:0]   GOAL    = (CNT_W+1)'(TARGET);

  logic [CNT_W-1:0] run_cnt;
  logic [CNT_W:0]   run_inc;

  always_comb begin
    run_inc      = {1'b0, run_cnt} + 1'b1;
    run_complete = frame_match && (run_inc >= GOAL);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (accept) begin
      if (!frame_match || enter_dsd) run_cnt <= '0;
      else if (run_cnt != CNT_MAX)   run_cnt <= run_cnt + 1'b1;
    end
  end

  assert_clear_on_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !frame_match) |=> (run_cnt == '0));
  assert_count_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(run_cnt));
endmodule

// File: rtl/dop_mode_fsm.sv
module dop_mode_fsm
  import dop_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic frame_match,
  input  logic left_is_inverse,
  input  logic run_complete,
  output logic enter_dsd,
  output logic dsd_mode,
  output logic mode_toggle
);
  stream_mode_e mode_q;
  logic         leave_dsd;

  always_comb begin
    enter_dsd = accept && (mode_q == MODE_PCM) && run_complete;
    leave_dsd = accept && (mode_q == MODE_DSD) && !frame_match && !left_is_inverse;
    dsd_mode  = (mode_q == MODE_DSD);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q      <= MODE_PCM;
      mode_toggle <= 1'b0;
    end else begin
      mode_toggle <= enter_dsd || leave_dsd;
      if (enter_dsd)      mode_q <= MODE_DSD;
      else if (leave_dsd) mode_q <= MODE_PCM;
    end
  end

  assert_pulse_on_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dsd_mode) |-> mode_toggle);
  assert_pulse_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dsd_mode) |-> mode_toggle);
  assert_pulse_only_on_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_toggle |-> ($rose(dsd_mode) || $fell(dsd_mode)));
  assert_mode_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(dsd_mode));
  assert_tolerant_stay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dsd_mode && left_is_inverse) |=> dsd_mode);
endmodule

// File: rtl/dop_frame_detector.sv
module dop_frame_detector
  import dop_pkg::*;
#(
  parameter int unsigned      WORD_W   = SAMPLE_W,
  parameter int unsigned      MARK_W   = TAG_W,
  parameter int unsigned      RUN_GOAL = 32,
  parameter logic [MARK_W-1:0] SEED    = 8'h05
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_left,
  input  logic [WORD_W-1:0] in_right,
  output logic              dsd_mode,
  output logic              mode_toggle
);
  localparam int unsigned TOP = WORD_W - 1;

  logic [MARK_W-1:0] left_tag, right_tag, expect_tag;
  logic accept, frame_match, left_is_inverse, run_complete, enter_dsd;

  assign in_ready  = 1'b1;
  assign accept    = in_valid;
  assign left_tag  = in_left[TOP -: MARK_W];
  assign right_tag = in_right[TOP -: MARK_W];

  dop_marker_compare #(.TAG_W(MARK_W)) u_cmp (
    .left_tag(left_tag), .right_tag(right_tag), .expect_tag(expect_tag),
    .frame_match(frame_match), .left_is_inverse(left_is_inverse)
  );

  dop_marker_tracker #(.TAG_W(MARK_W), .SEED(SEED)) u_trk (
    .clk(clk), .rst_n(rst_n), .accept(accept), .frame_match(frame_match),
    .enter_dsd(enter_dsd), .expect_tag(expect_tag)
  );

  dop_run_counter #(.TARGET(RUN_GOAL)) u_run (
    .clk(clk), .rst_n(rst_n), .accept(accept), .frame_match(frame_match),
    .enter_dsd(enter_dsd), .run_complete(run_complete)
  );

  dop_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .accept(accept), .frame_match(frame_match),
    .left_is_inverse(left_is_inverse), .run_complete(run_complete),
    .enter_dsd(enter_dsd), .dsd_mode(dsd_mode), .mode_toggle(mode_toggle)
  );

  assert_match_needs_both_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (left_tag != right_tag)) |=> $stable(expect_tag));
endmodule

// File: tb/dop_frame_detector_tb.sv
module dop_frame_detector_tb;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_left = '0;
  logic [31:0] in_right = '0;
  logic        dsd_mode, mode_toggle;

  int tests = 0;
  int fails = 0;

  // behavioural reference
  int m_expect = 'h05;
  int m_run = 0;
  bit m_dsd = 0;
  bit m_tog = 0;
  int gen_mark = 'h05;

  dop_frame_detector u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right),
    .dsd_mode(dsd_mode), .mode_toggle(mode_toggle)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, int act, int exp, string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model(bit v, int l, int r);
    int lt = (l >> 24) & 'hFF;
    int rt = (r >> 24) & 'hFF;
    bit was = m_dsd;
    if (v) begin
      if (lt == m_expect && rt == m_expect) begin
        m_expect ^= 'hFF;
        if (m_run < 63) m_run++;
        if (!m_dsd && m_run >= 32) begin
          m_run = 0; m_dsd = 1; m_expect ^= 'hFF;
        end
      end else begin
        m_run = 0;
        if (m_dsd && lt != (m_expect ^ 'hFF)) m_dsd = 0;
      end
    end
    m_tog = (was != m_dsd);
  endtask

  task automatic step(bit v, logic [31:0] l, logic [31:0] r, string tag);
    in_valid = v; in_left = l; in_right = r;
    @(posedge clk);
    @(negedge clk);
    model(v, l, r);
    check(tag, dsd_mode, m_dsd, "dsd_mode");
    check(tag, mode_toggle, m_tog, "mode_toggle");
    check("R10", in_ready, 1, "in_ready");
  endtask

  task automatic stream(int n, string tag);
    for (int i = 0; i < n; i++) begin
      step(1, {gen_mark[7:0], 24'($urandom)}, {gen_mark[7:0], 24'($urandom)}, tag);
      gen_mark ^= 'hFF;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    fails++; tests++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R2", dsd_mode, 0, "reset dsd_mode");
    check("R2", mode_toggle, 0, "reset mode_toggle");
    rst_n = 1'b1;
    // R3/R6: 31 good frames then a right-only break
    stream(31, "R3");
    step(1, {gen_mark[7:0], 24'h123456}, 32'h00ABCDEF, "R6");
    check("R6", dsd_mode, 0, "no entry after broken run");
    // R11: marker keeps its phase; the alternating stream resyncs via model
    stream(5, "R11");
    // R10: idle cycles with garbage
    for (int i = 0; i < 6; i++) step(0, 32'h05000000, 32'h05000000, "R10");
    // R1/R4/R9: fresh full run into DSD
    step(1, 32'h77000000, 32'h77000000, "R6");
    gen_mark = m_expect;
    stream(40, "R4");
    check("R4", dsd_mode, 1, "entered DSD");
    // R5/R7: continuing stream stays in DSD
    stream(12, "R7");
    check("R7", dsd_mode, 1, "tolerant stay");
    for (int i = 0; i < 4; i++) step(0, 32'hDEADBEEF, 32'h0, "R10");
    check("R10", dsd_mode, 1, "idle keeps DSD");
    // R8: plain PCM frame exits
    step(1, 32'h00112233, 32'h00445566, "R8");
    check("R8", dsd_mode, 0, "exit to PCM");
    // re-enter, then right-only break with left inverse keeps, left garbage exits
    gen_mark = m_expect;
    stream(33, "R9");
    check("R9", dsd_mode, 1, "re-entered");
    step(1, {8'(m_expect ^ 'hFF), 24'h0}, 32'h33000000, "R7");
    step(1, 32'h42000000, {8'(m_expect), 24'h0}, "R8");
    check("R8", dsd_mode, 0, "left garbage exit");
    // R1: lower bits never matter, long run past saturation
    gen_mark = m_expect;
    stream(70, "R1");
    step(1, 32'h00FFFFFF, 32'h00FFFFFF, "R8");
    // R2: reset returns the marker to 0x05
    rst_n = 1'b0;
    step(0, 0, 0, "R2");
    m_expect = 'h05; m_run = 0; m_dsd = 0; m_tog = 0;
    rst_n = 1'b1;
    gen_mark = 'h05;
    stream(32, "R2");
    check("R2", dsd_mode, 1, "entry from seed 0x05");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule